// File: doc/BRIEF.md
# Store Queue with Registered Full Flag

This block is a small synchronous first-in first-out queue placed between a processor's load/store unit and its data bus. Each pending store occupies one slot holding a 32-bit address, 32-bit data and a 4-bit byte-enable mask. The load/store unit pushes stores on the write side, and the bus side drains them in the order they were pushed. The read side always presents the oldest slot together with a valid flag, and a pop strobe removes it.

The full indication is taken straight from a flip-flop, so the pipeline stall path begins at a register output with no gates in front of it. To make that possible, the next value of the flag is decided one cycle ahead from the occupancy count. This decision does not look at a read in the same cycle. When a read and a write arrive together with exactly one slot free, the flag is therefore raised for a single cycle although space remains. The stall output is the full flag itself.

Top module: `store_queue`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, full and stall are 0 and rd_valid is 0.
- R2: Entries leave in the order they were accepted. rd_addr, rd_data and rd_be always show the oldest held entry, and a pop accepted at a clock edge moves the oldest entry out at that edge.
- R3: full is 1 in the cycle after an edge at which a write was accepted with exactly DEPTH-1 entries held, or at which DEPTH entries were held. In every other case full is 0 after the edge.
- R4: If a read and a write are both accepted at an edge with DEPTH-1 entries held, full is 1 for the next cycle only. It is 0 again in the cycle after that unless one of the R3 conditions occurs again.
- R5: full is never 0 while the queue holds DEPTH entries.
- R6: A write request while full is 1 is ignored. No entry is added and the held entries and their order are unchanged.
- R7: A pop request while rd_valid is 0 is ignored. A write in that same cycle is still accepted.
- R8: stall equals full in every cycle.
- R9: rd_valid is 1 exactly when at least one entry is held. An entry written into an empty queue is presented in the cycle after the write edge.
- R10: DEPTH is a parameter that defaults to 16 and must be a power of two of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_req | input | 1 | Push a store; accepted when full is 0 |
| wr_addr | input | 32 | Store address to queue |
| wr_data | input | 32 | Store data to queue |
| wr_be | input | 4 | Byte-enable mask to queue |
| full | output | 1 | Registered full flag |
| stall | output | 1 | Pipeline stall request, equal to full |
| rd_valid | output | 1 | Oldest entry is present on the read side |
| rd_addr | output | 32 | Address of the oldest entry |
| rd_data | output | 32 | Data of the oldest entry |
| rd_be | output | 4 | Byte-enable mask of the oldest entry |
| rd_pop | input | 1 | Remove the oldest entry; accepted when rd_valid is 1 |

## Verification
A wrong occupancy count shows at full and stall one cycle after the edge that corrupted it. The count either fails to raise the flag at the one-slot-left write or holds the flag past the single pessimistic cycle. A pointer error shows on the read side at once, the next cycle, as a wrong head entry or a rd_valid that disagrees with the number of pushes and pops accepted. A write that slips past a set flag shows as an extra entry or an overwritten slot when the queue is drained, so the bench drains every fill and compares each head against a queue model.

// File: rtl/stq_pkg.sv
package stq_pkg;

  localparam int unsigned STQ_ADDR_W    = 32;
  localparam int unsigned STQ_DATA_W    = 32;
  localparam int unsigned STQ_BE_W      = 4;
  localparam int unsigned STQ_DEPTH_DEF = 16;

  typedef struct packed {
    logic [STQ_ADDR_W-1:0] addr;
    logic [STQ_DATA_W-1:0] data;
    logic [STQ_BE_W-1:0]   be;
  } stq_entry_t;

endpackage

// File: rtl/stq_ptrs.sv
module stq_ptrs #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic          empty
);

  // One extra wrap bit so equal indices can be told apart as empty or full.
  logic [PW:0] wr_ptr_q, wr_ptr_d;
  logic [PW:0] rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = wr_ptr_q + (PW+1)'(1);
    if (pop)  rd_ptr_d = rd_ptr_q + (PW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_d;
      if (pop)  rd_ptr_q <= rd_ptr_d;
    end
  end

  assign wr_idx = wr_ptr_q[PW-1:0];
  assign rd_idx = rd_ptr_q[PW-1:0];
  assign empty  = (wr_ptr_q == rd_ptr_q);

endmodule

// File: rtl/stq_occupancy.sv
module stq_occupancy #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam logic [CW-1:0] CNT_MAX      = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE_LEFT = CW'(DEPTH - 1);

  logic [CW-1:0] count_q, count_d;
  logic          full_q, full_d;
  logic          one_left, none_left;

  always_comb begin
    count_d = count_q;
    unique case ({push, pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  // Next full looks only at the write side; a same-cycle pop is ignored on
  // purpose, so the flag may be raised one cycle early.
  always_comb begin
    one_left  = (count_q == CNT_ONE_LEFT);
    none_left = (count_q == CNT_MAX);
    full_d    = (push & one_left) | none_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (push ^ pop) count_q <= count_d;
      full_q <= full_d;
    end
  end

  assign count = count_q;
  assign full  = full_q;

endmodule

// File: rtl/stq_storage.sv
module stq_storage
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  stq_entry_t    wr_entry,
  input  logic [PW-1:0] rd_idx,
  output stq_entry_t    rd_entry
);

  stq_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == PW'(g));
    // Payload registers carry no reset; validity lives in the pointers.
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_idx];

endmodule

// File: rtl/store_queue.sv
module store_queue
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = STQ_DEPTH_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [STQ_ADDR_W-1:0] wr_addr,
  input  logic [STQ_DATA_W-1:0] wr_data,
  input  logic [STQ_BE_W-1:0]   wr_be,
  output logic                  full,
  output logic                  stall,
  output logic                  rd_valid,
  output logic [STQ_ADDR_W-1:0] rd_addr,
  output logic [STQ_DATA_W-1:0] rd_data,
  output logic [STQ_BE_W-1:0]   rd_be,
  input  logic                  rd_pop
);

  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          full_q;
  logic          empty;
  logic          push, pop;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] occ_count;
  stq_entry_t    wr_entry, rd_entry;

  // R6 / R7: requests are gated by the registered flags only.
  assign push = wr_req & ~full_q;
  assign pop  = rd_pop & ~empty;

  assign wr_entry.addr = wr_addr;
  assign wr_entry.data = wr_data;
  assign wr_entry.be   = wr_be;

  stq_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .empty  (empty)
  );

  stq_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .count (occ_count),
    .full  (full_q)
  );

  stq_storage #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk      (clk),
    .wr_en    (push),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .rd_idx   (rd_idx),
    .rd_entry (rd_entry)
  );

  assign full     = full_q;
  assign stall    = full_q;   // R8
  assign rd_valid = ~empty;
  assign rd_addr  = rd_entry.addr;
  assign rd_data  = rd_entry.data;
  assign rd_be    = rd_entry.be;

endmodule

// File: rtl/store_queue_checker.sv
module store_queue_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_pop,
  input logic          full,
  input logic          rd_valid,
  input logic [CW-1:0] count
);

  // R10
  initial begin
    depth_pow2_chk: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0);
  end

  // R5
  full_when_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> full);

  // R3
  one_left_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH - 1) && wr_req && !full) |=> full);

  // R4
  early_full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && count != CW'(DEPTH)) |=> !full);

  // R6
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_pop) |=> $stable(count));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && rd_pop && !wr_req) |=> !rd_valid);

  // R9
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (count != '0));

endmodule

bind store_queue store_queue_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_req   (wr_req),
  .rd_pop   (rd_pop),
  .full     (full),
  .rd_valid (rd_valid),
  .count    (occ_count)
);

// File: tb/store_queue_bench.sv
module store_queue_bench;

  localparam int TB_DEPTH = 4;
  localparam int NSTEP    = 16;
  // Each vector: {write request, pop request, expected full after the edge}
  localparam logic [2:0] VEC [NSTEP] = '{
    3'b100, 3'b100, 3'b100, 3'b101,   // fill; last write at one-left (R3)
    3'b101,                           // write while full, ignored (R6)
    3'b011,                           // pop from full: still reports full (R3)
    3'b000,                           // released
    3'b111,                           // pessimistic read+write at one-left (R4)
    3'b110,                           // write blocked, pop taken: flag drops
    3'b100, 3'b010, 3'b010, 3'b010,
    3'b010,                           // pop while empty, ignored (R7)
    3'b110,                           // write+pop on empty: write kept (R7)
    3'b010
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_req, rd_pop;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic        full, stall, rd_valid;
  logic [31:0] rd_addr, rd_data;
  logic [3:0]  rd_be;

  int checks = 0;
  int errors = 0;
  logic [67:0] model_q [$];
  bit prev_full;

  always #5 clk = ~clk;

  store_queue #(.DEPTH(TB_DEPTH)) u_store_queue (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .full(full), .stall(stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_be(rd_be), .rd_pop(rd_pop)
  );

  task automatic chk(input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [67:0] make_entry(input int idx);
    logic [31:0] a, d;
    a = 32'h4000_0000 + 32'(idx) * 32'd16;
    d = 32'hC3A5_0000 ^ (32'(idx) * 32'h0001_0203);
    return {a, d, 4'(idx)};
  endfunction

  task automatic run_step(input bit wr, input bit rd, input bit exp_full,
                          input int idx);
    logic [67:0] ent;
    bit wacc, racc;
    @(negedge clk);
    ent = make_entry(idx);
    wr_req = wr; rd_pop = rd;
    {wr_addr, wr_data, wr_be} = ent;
    #1;
    chk("R9", "rd_valid", 68'(rd_valid), 68'(model_q.size() != 0));
    if (model_q.size() != 0)
      chk("R2", "head entry", {rd_addr, rd_data, rd_be}, model_q[0]);
    wacc = wr && !prev_full;
    racc = rd && (model_q.size() != 0);
    @(posedge clk);
    #1;
    if (racc) void'(model_q.pop_front());
    if (wacc) model_q.push_back(ent);
    if (exp_full && model_q.size() < TB_DEPTH)
      chk("R4", "full", 68'(full), 68'(exp_full));
    else
      chk("R3", "full", 68'(full), 68'(exp_full));
    chk("R8", "stall", 68'(stall), 68'(full));
    if (model_q.size() == TB_DEPTH) chk("R5", "full at depth", 68'(full), 68'd1);
    prev_full = exp_full;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_req = 1'b0; rd_pop = 1'b0;
    wr_addr = '0; wr_data = '0; wr_be = '0;
    prev_full = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "full in reset", 68'(full), 68'd0);
    chk("R1", "valid in reset", 68'(rd_valid), 68'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "full after release", 68'(full), 68'd0);
    chk("R1", "stall after release", 68'(stall), 68'd0);
    chk("R1", "valid after release", 68'(rd_valid), 68'd0);

    for (int i = 0; i < NSTEP; i++)
      run_step(VEC[i][2], VEC[i][1], VEC[i][0], i + 1);

    // R6: fill completely, hammer writes, then drain and compare order.
    for (int i = 0; i < TB_DEPTH - 1; i++) run_step(1'b1, 1'b0, 1'b0, 40 + i);
    run_step(1'b1, 1'b0, 1'b1, 50);
    for (int i = 0; i < 3; i++) run_step(1'b1, 1'b0, 1'b1, 60 + i);
    chk("R6", "held after blocked writes", 68'(model_q.size()), 68'(TB_DEPTH));
    run_step(1'b0, 1'b1, 1'b1, 70);
    for (int i = 0; i < TB_DEPTH - 1; i++) run_step(1'b0, 1'b1, 1'b0, 71 + i);
    chk("R6", "drained", 68'(rd_valid), 68'd0);

    // R9: entry written into an empty queue appears the next cycle.
    run_step(1'b1, 1'b0, 1'b0, 80);
    chk("R9", "valid after single write", 68'(rd_valid), 68'd1);
    chk("R9", "head after single write", {rd_addr, rd_data, rd_be}, make_entry(80));

    // R1: asynchronous reset with entries held and full set.
    for (int i = 0; i < TB_DEPTH - 2; i++) run_step(1'b1, 1'b0, 1'b0, 90 + i);
    run_step(1'b1, 1'b0, 1'b1, 95);
    @(negedge clk);
    wr_req = 1'b0; rd_pop = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "full on reset", 68'(full), 68'd0);
    chk("R1", "valid on reset", 68'(rd_valid), 68'd0);
    chk("R8", "stall on reset", 68'(stall), 68'd0);
    @(negedge clk) rst_n = 1'b1;
    model_q.delete();
    prev_full = 1'b0;
    run_step(1'b1, 1'b0, 1'b0, 99);
    chk("R2", "head after reset", {rd_addr, rd_data, rd_be}, make_entry(99));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule